// File: doc/BRIEF.md
# Program Flow Trace Packet Decoder

This block sits behind a byte-wide program-flow trace port and turns the raw byte stream into waypoint events. A waypoint is an instruction that can redirect program flow: an indirect branch, a direct branch (conditional or not), an exception, or a change of instruction-set or security state. The trace reports each waypoint as either a branch-address packet, meaning the branch was taken and a new target is known, or an atom packet, which carries only a taken/not-taken outcome.

The decoder first hunts for the stream alignment pattern, a run of zero bytes closed by 0x80. It then requires an instruction-sync packet, which loads the full current address. Only after both does it decode headers. Each header is sorted into one of eleven packet classes or marked reserved. Classes with no meaning for flow tracking are stepped over by their length rules. A reserved header, or a malformed payload, drops alignment. Output then stays silent until the alignment pattern and an instruction sync are seen again.

One byte is accepted per cycle whenever the input is valid. The ready output is always high. Events are registered and appear one cycle after the byte that completes them.

Top module: `trace_flow_decoder`

## Requirements
- R1: After reset, and whenever alignment is lost, `synced_o` is low and no event is produced. Alignment needs an alignment pattern immediately followed by an instruction-sync packet (header 0x08). Any other byte directly after the pattern drops back to the hunt.
- R2: The alignment pattern is at least five consecutive 0x00 bytes followed by 0x80. A 0x80 after fewer than five zeros, or with no zeros before it, is not taken as alignment.
- R3: An instruction-sync packet is header 0x08, then four address bytes least-significant first, then one information byte. The cycle after the information byte, `ev_valid_o` pulses with kind 1, taken 0 and the loaded address, and `synced_o` is high. An instruction sync met while decoding reloads the address the same way without dropping `synced_o`.
- R4: While decoding, a header with bit 7 set and bit 0 clear is an atom. It yields an event of kind 3 whose taken flag is header bit 1 (0 = not taken) and whose address is the current address, unchanged.
- R5: While decoding, a header with bit 0 set is a branch address. Header bits 6:1 replace address bits 6:1. Each later byte k (k = 1, 2, 3) replaces address bits 7k+6:7k with its bits 6:0. A fifth byte replaces bits 31:28 with its bits 3:0. Bit 7 of every byte except the fifth means another byte follows. Address bit 0 becomes 0, and bits not sent keep their previous value. The cycle after the last byte, an event of kind 2 with taken 1 and the new address appears, and that address becomes current.
- R6: A fifth branch-address byte with bit 7 set is malformed and drops alignment.
- R7: Headers 0x0C, 0x76 and 0x66 stand alone. Header 0x3C takes one following byte and 0x6E takes four. Headers 0x42/0x46 are followed by continuation bytes (bit 7 = more), at most nine; 0x72 likewise, at most five. These packets produce no event, and their payload bytes are never taken as headers. Exceeding the continuation limit drops alignment.
- R8: Any other header while decoding (for example 0x02) is reserved and drops alignment.
- R9: A 0x00 header while decoding drops alignment and counts as the first zero of a new alignment pattern.
- R10: Cycles with `in_valid_i` low consume nothing and change no state, even in the middle of a packet; `in_ready_o` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Trace byte present |
| in_data_i | input | 8 | Trace byte |
| in_ready_o | output | 1 | Byte accepted (always high) |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_kind_o | output | 2 | 1 = instruction sync, 2 = branch address, 3 = atom |
| ev_taken_o | output | 1 | Waypoint taken flag |
| ev_addr_o | output | 32 | Address attached to the event |
| synced_o | output | 1 | Decoder aligned and decoding |

## Verification
Every event is due exactly one clock after the byte that closes its packet. This holds for the information byte of an instruction sync, an atom header, and the last byte of a branch address. Loss or gain of `synced_o` follows the same single-register delay. The bench applies each byte at a falling edge and advances a behavioural model one byte at a time. At the next falling edge it compares the strobe, the alignment flag and, when an event is expected, its kind, flag and address. Idle cycles advance the model with no byte, so gaps test that state is held.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

  typedef enum logic [3:0] {
    PK_ASYNC, PK_ISYNC, PK_ATOM, PK_BRANCH, PK_WPUPD, PK_TRIG,
    PK_CTXID, PK_VMID, PK_TSTAMP, PK_EXCRET, PK_IGNORE, PK_RSVD
  } pkt_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0, EV_SYNC = 2'd1, EV_BRANCH = 2'd2, EV_ATOM = 2'd3
  } ev_e;

  typedef enum logic [2:0] {
    ST_HUNT, ST_WAITI, ST_IADDR, ST_IINFO, ST_DEC, ST_BADDR, ST_SKIPF, ST_SKIPC
  } st_e;

  // Sort a header byte into its packet class; bit 0 and bit 7 take priority.
  function automatic pkt_e classify(input logic [7:0] b);
    pkt_e k;
    if (b[0])      k = PK_BRANCH;
    else if (b[7]) k = PK_ATOM;
    else begin
      case (b)
        8'h00:        k = PK_ASYNC;
        8'h08:        k = PK_ISYNC;
        8'h0C:        k = PK_TRIG;
        8'h72:        k = PK_WPUPD;
        8'h6E:        k = PK_CTXID;
        8'h3C:        k = PK_VMID;
        8'h42, 8'h46: k = PK_TSTAMP;
        8'h76:        k = PK_EXCRET;
        8'h66:        k = PK_IGNORE;
        default:      k = PK_RSVD;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/tdec_zero_run.sv
module tdec_zero_run #(
  parameter int MIN_ZEROS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic zero_hit_i,
  output logic run_ok_o
);
  localparam int ZW = $clog2(MIN_ZEROS + 1);

  logic [ZW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (!zero_hit_i)                   cnt_q <= '0;
      else if (cnt_q != ZW'(MIN_ZEROS))  cnt_q <= cnt_q + ZW'(1);
    end
  end

  assign run_ok_o = (cnt_q == ZW'(MIN_ZEROS));

  // R2
  zero_break_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !zero_hit_i) |=> !run_ok_o);

endmodule

// File: rtl/tdec_hdr_class.sv
module tdec_hdr_class import tdec_pkg::*; #(
  parameter int CTX_BYTES  = 4,
  parameter int VMID_BYTES = 1,
  parameter int TS_MAX     = 9,
  parameter int WP_MAX     = 5,
  parameter int LW         = 4
) (
  input  logic [7:0]    hdr_i,
  output pkt_e          kind_o,
  output logic          fixed_o,
  output logic [LW-1:0] fix_len_o,
  output logic          cont_o,
  output logic [LW-1:0] cont_max_o
);
  always_comb begin
    kind_o     = classify(hdr_i);
    fixed_o    = 1'b0;
    fix_len_o  = '0;
    cont_o     = 1'b0;
    cont_max_o = '0;
    case (kind_o)
      PK_TRIG, PK_EXCRET, PK_IGNORE: fixed_o = 1'b1;
      PK_CTXID:  begin fixed_o = 1'b1; fix_len_o  = LW'(CTX_BYTES);  end
      PK_VMID:   begin fixed_o = 1'b1; fix_len_o  = LW'(VMID_BYTES); end
      PK_TSTAMP: begin cont_o  = 1'b1; cont_max_o = LW'(TS_MAX);     end
      PK_WPUPD:  begin cont_o  = 1'b1; cont_max_o = LW'(WP_MAX);     end
      default: ;
    endcase
  end
endmodule

// File: rtl/tdec_addr_merge.sv
module tdec_addr_merge #(
  parameter int AW = 32,
  parameter int NB = 5,
  parameter int IW = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [7:0]    byte_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o,
  output logic          more_o,
  output logic          bad_o
);
  // Lane L carries address bits 7L..7L+6 in byte bits 0..6.
  assign addr_o[0] = 1'b0;
  for (genvar b = 1; b < AW; b++) begin : g_bit
    assign addr_o[b] = (idx_i == IW'(b / 7)) ? byte_i[b % 7] : base_i[b];
  end

  assign more_o = byte_i[7];
  assign bad_o  = byte_i[7] && (idx_i == IW'(NB - 1));
endmodule

// File: rtl/trace_flow_decoder.sv
module trace_flow_decoder import tdec_pkg::*; #(
  parameter int AW         = 32,
  parameter int MIN_ZEROS  = 5,
  parameter int BR_BYTES   = 5,
  parameter int CTX_BYTES  = 4,
  parameter int VMID_BYTES = 1,
  parameter int TS_MAX     = 9,
  parameter int WP_MAX     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  output logic          in_ready_o,
  output logic          ev_valid_o,
  output logic [1:0]    ev_kind_o,
  output logic          ev_taken_o,
  output logic [AW-1:0] ev_addr_o,
  output logic          synced_o
);
  localparam int IS_BYTES = AW / 8;
  localparam int CNT_W    = $clog2(TS_MAX + CTX_BYTES + IS_BYTES + BR_BYTES + 1);
  localparam int IW       = $clog2(BR_BYTES);

  st_e             st_q, st_d;
  logic [AW-1:0]   cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic            lock_q, lock_d;
  logic            ev_v_q, ev_v_d, ev_t_q, ev_t_d;
  ev_e             ev_k_q, ev_k_d;
  logic [AW-1:0]   ev_a_q, ev_a_d;

  logic            zero_hit, run_ok;
  pkt_e            hdr_kind;
  logic            hdr_fixed, hdr_cont;
  logic [CNT_W-1:0] hdr_len, hdr_max;
  logic [IW-1:0]   m_idx;
  logic [AW-1:0]   m_addr;
  logic            m_more, m_bad;

  assign zero_hit = (in_data_i == 8'h00) &&
                    (st_q == ST_HUNT || st_q == ST_WAITI || st_q == ST_DEC);

  tdec_zero_run #(.MIN_ZEROS(MIN_ZEROS)) u_zero_run (
    .clk(clk), .rst(rst), .step_i(in_valid_i), .zero_hit_i(zero_hit),
    .run_ok_o(run_ok)
  );

  tdec_hdr_class #(
    .CTX_BYTES(CTX_BYTES), .VMID_BYTES(VMID_BYTES),
    .TS_MAX(TS_MAX), .WP_MAX(WP_MAX), .LW(CNT_W)
  ) u_hdr_class (
    .hdr_i(in_data_i), .kind_o(hdr_kind), .fixed_o(hdr_fixed),
    .fix_len_o(hdr_len), .cont_o(hdr_cont), .cont_max_o(hdr_max)
  );

  assign m_idx = (st_q == ST_DEC) ? '0 : IW'(cnt_q);

  tdec_addr_merge #(.AW(AW), .NB(BR_BYTES), .IW(IW)) u_addr_merge (
    .base_i(cur_q), .byte_i(in_data_i), .idx_i(m_idx),
    .addr_o(m_addr), .more_o(m_more), .bad_o(m_bad)
  );

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    ev_v_d = 1'b0;
    ev_k_d = EV_NONE;
    ev_t_d = 1'b0;
    ev_a_d = ev_a_q;
    if (in_valid_i) begin
      case (st_q)
        ST_HUNT: if (in_data_i == 8'h80 && run_ok) st_d = ST_WAITI;
        ST_WAITI: begin
          if (in_data_i == 8'h08) begin
            st_d  = ST_IADDR;
            cnt_d = '0;
          end else begin
            st_d = ST_HUNT;
          end
        end
        ST_IADDR: begin
          for (int i = 0; i < IS_BYTES; i++)
            if (cnt_q == CNT_W'(i)) cur_d[8*i +: 8] = in_data_i;
          if (cnt_q == CNT_W'(IS_BYTES - 1)) st_d = ST_IINFO;
          else                               cnt_d = cnt_q + CNT_W'(1);
        end
        ST_IINFO: begin
          st_d   = ST_DEC;
          ev_v_d = 1'b1;
          ev_k_d = EV_SYNC;
          ev_a_d = cur_q;
        end
        ST_DEC: begin
          case (hdr_kind)
            PK_BRANCH: begin
              cur_d = m_addr;
              if (m_more) begin
                st_d  = ST_BADDR;
                cnt_d = CNT_W'(1);
              end else begin
                ev_v_d = 1'b1; ev_k_d = EV_BRANCH; ev_t_d = 1'b1; ev_a_d = m_addr;
              end
            end
            PK_ATOM: begin
              ev_v_d = 1'b1; ev_k_d = EV_ATOM; ev_t_d = in_data_i[1]; ev_a_d = cur_q;
            end
            PK_ISYNC: begin
              st_d  = ST_IADDR;
              cnt_d = '0;
            end
            PK_ASYNC, PK_RSVD: st_d = ST_HUNT;
            default: begin
              if (hdr_cont) begin
                st_d  = ST_SKIPC;
                cnt_d = '0;
                lim_d = hdr_max;
              end else if (hdr_fixed && hdr_len != '0) begin
                st_d  = ST_SKIPF;
                cnt_d = hdr_len;
              end
            end
          endcase
        end
        ST_BADDR: begin
          if (m_bad) begin
            st_d = ST_HUNT;
          end else begin
            cur_d = m_addr;
            if (m_more) begin
              cnt_d = cnt_q + CNT_W'(1);
            end else begin
              st_d   = ST_DEC;
              ev_v_d = 1'b1; ev_k_d = EV_BRANCH; ev_t_d = 1'b1; ev_a_d = m_addr;
            end
          end
        end
        ST_SKIPF: begin
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_d = ST_DEC;
        end
        ST_SKIPC: begin
          if (!in_data_i[7])                   st_d = ST_DEC;
          else if (cnt_q == lim_q - CNT_W'(1)) st_d = ST_HUNT;
          else                                 cnt_d = cnt_q + CNT_W'(1);
        end
        default: st_d = ST_HUNT;
      endcase
    end
    lock_d = lock_q;
    if (in_valid_i && st_q == ST_IINFO) lock_d = 1'b1;
    if (st_d == ST_HUNT)                lock_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HUNT;
      cur_q  <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
      lock_q <= 1'b0;
      ev_v_q <= 1'b0;
      ev_k_q <= EV_NONE;
      ev_t_q <= 1'b0;
      ev_a_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      lock_q <= lock_d;
      ev_v_q <= ev_v_d;
      ev_k_q <= ev_k_d;
      ev_t_q <= ev_t_d;
      ev_a_q <= ev_a_d;
    end
  end

  assign in_ready_o = 1'b1;
  assign ev_valid_o = ev_v_q;
  assign ev_kind_o  = ev_k_q;
  assign ev_taken_o = ev_t_q;
  assign ev_addr_o  = ev_a_q;
  assign synced_o   = lock_q;

  // R1
  ev_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid_o |-> synced_o);

  // R3
  lock_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(synced_o) |-> (ev_valid_o && ev_kind_o == EV_SYNC));

  // R4
  atom_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_o && ev_kind_o == EV_ATOM) |-> (ev_addr_o == $past(cur_q)));

  // R5
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_o && ev_kind_o == EV_BRANCH) |-> ev_taken_o);

  // R6
  addr_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && st_q == ST_BADDR && cnt_q == CNT_W'(BR_BYTES - 1) && in_data_i[7])
    |=> (!synced_o && !ev_valid_o));

  // R8
  rsvd_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && st_q == ST_DEC && hdr_kind == PK_RSVD) |=> (!synced_o && !ev_valid_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> ($stable(st_q) && $stable(cur_q) && !ev_valid_o));

endmodule

// File: tb/trace_flow_decoder_bench.sv
`timescale 1ns/1ps
module trace_flow_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = 8'h00;
  logic        in_ready_o, ev_valid_o, ev_taken_o, synced_o;
  logic [1:0]  ev_kind_o;
  logic [31:0] ev_addr_o;

  always #5 clk = ~clk;

  trace_flow_decoder u_trace_flow_decoder (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .ev_valid_o(ev_valid_o), .ev_kind_o(ev_kind_o),
    .ev_taken_o(ev_taken_o), .ev_addr_o(ev_addr_o), .synced_o(synced_o)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  // expected outputs after the next rising edge
  logic        exp_v = 0, exp_t = 0, exp_s = 0;
  logic [1:0]  exp_k = 0;
  logic [31:0] exp_a = 0;

  // behavioural model: 0 hunt, 1 wait sync, 2 sync addr, 3 sync info,
  // 4 decode, 5 branch bytes, 6 fixed skip, 7 continuation skip
  int ms = 0, mz = 0, mi = 0, rem = 0, lim = 0;
  logic [31:0] ma = 0;
  logic ml = 0;

  task automatic emit(input logic [1:0] k, input logic t);
    exp_v = 1; exp_k = k; exp_t = t; exp_a = ma;
  endtask

  task automatic lose();
    ms = 0; ml = 0;
  endtask

  task automatic model(input logic [7:0] b);
    int old;
    old = ms;
    exp_v = 0;
    case (ms)
      0: if (b == 8'h80 && mz >= 5) ms = 1;
      1: if (b == 8'h08) begin ms = 2; mi = 0; end else lose();
      2: begin
        for (int k = 0; k < 8; k++) ma[8*mi + k] = b[k];
        mi++;
        if (mi == 4) ms = 3;
      end
      3: begin ms = 4; ml = 1; emit(2'd1, 1'b0); end
      4: begin
        if (b[0]) begin
          for (int k = 1; k < 7; k++) ma[k] = b[k];
          ma[0] = 1'b0;
          if (b[7]) begin ms = 5; mi = 1; end else emit(2'd2, 1'b1);
        end else if (b[7]) emit(2'd3, b[1]);
        else if (b == 8'h00) lose();
        else if (b == 8'h08) begin ms = 2; mi = 0; end
        else if (b == 8'h0C || b == 8'h76 || b == 8'h66) ;
        else if (b == 8'h3C) begin ms = 6; rem = 1; end
        else if (b == 8'h6E) begin ms = 6; rem = 4; end
        else if (b == 8'h42 || b == 8'h46) begin ms = 7; mi = 0; lim = 9; end
        else if (b == 8'h72) begin ms = 7; mi = 0; lim = 5; end
        else lose();
      end
      5: begin
        if (mi == 4 && b[7]) lose();
        else begin
          for (int k = 0; k < 7; k++) if (7*mi + k < 32) ma[7*mi + k] = b[k];
          if (b[7]) mi++;
          else begin ms = 4; emit(2'd2, 1'b1); end
        end
      end
      6: begin rem--; if (rem == 0) ms = 4; end
      default: begin
        if (!b[7]) ms = 4;
        else begin mi++; if (mi == lim) lose(); end
      end
    endcase
    if (b == 8'h00 && (old == 0 || old == 1 || old == 4)) mz++;
    else mz = 0;
    exp_s = ml;
  endtask

  task automatic check();
    vectors++;
    if (synced_o !== exp_s) begin
      fails++; $display("FAIL %s synced_o got %0b exp %0b", req, synced_o, exp_s);
    end
    if (ev_valid_o !== exp_v) begin
      fails++; $display("FAIL %s ev_valid_o got %0b exp %0b", req, ev_valid_o, exp_v);
    end else if (exp_v) begin
      if (ev_kind_o !== exp_k) begin
        fails++; $display("FAIL %s ev_kind_o got %0d exp %0d", req, ev_kind_o, exp_k);
      end
      if (ev_taken_o !== exp_t) begin
        fails++; $display("FAIL %s ev_taken_o got %0b exp %0b", req, ev_taken_o, exp_t);
      end
      if (ev_addr_o !== exp_a) begin
        fails++; $display("FAIL %s ev_addr_o got %h exp %h", req, ev_addr_o, exp_a);
      end
    end
    if (in_ready_o !== 1'b1) begin
      fails++; $display("FAIL R10 in_ready_o got %0b exp 1", in_ready_o);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    check();
    model(b);
    in_valid_i = 1'b1;
    in_data_i  = b;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      check();
      exp_v = 0;
      in_valid_i = 1'b0;
      in_data_i  = 8'h80;
    end
  endtask

  task automatic zeros(input int n);
    repeat (n) put(8'h00);
  endtask

  task automatic isync(input logic [31:0] a);
    put(8'h08); put(a[7:0]); put(a[15:8]); put(a[23:16]); put(a[31:24]); put(8'h00);
  endtask

  task automatic realign(input logic [31:0] a);
    zeros(5); put(8'h80); isync(a);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state then no decoding before alignment
    req = "R1";
    put(8'h84); put(8'h25); put(8'h80); put(8'h08); gap(2);
    // R2: short zero run and stray 0x80 are rejected
    req = "R2";
    zeros(4); put(8'h80); isync(32'h1111_2222); put(8'h80);
    put(8'h80); zeros(7); put(8'h80);
    // R3: sync loads address and reports it
    req = "R3";
    isync(32'h1234_5678);
    // R4: atoms of both outcomes
    req = "R4";
    put(8'h80); put(8'h82); put(8'hFE); put(8'h84);
    // R5: branch addresses of several lengths
    req = "R5";
    put(8'h25); put(8'h81); put(8'h85); put(8'h0A);
    put(8'hFF); put(8'hFF); put(8'hFF); put(8'hFF); put(8'h0A);
    put(8'hD3); put(8'h2C); put(8'h82);
    // R3: sync while decoding reloads without losing alignment
    req = "R3";
    isync(32'hDEAD_BEEF); put(8'h80);
    // R10: idle gaps inside a packet
    req = "R10";
    put(8'h81); gap(3); put(8'h7F); gap(1); put(8'h08); put(8'h01); gap(2);
    put(8'h02); put(8'h03); put(8'h04); gap(1); put(8'h05); put(8'h82);
    // R7: skipped packets, payloads resembling headers
    req = "R7";
    put(8'h0C); put(8'h76); put(8'h66); put(8'h80);
    put(8'h3C); put(8'h81); put(8'h82);
    put(8'h6E); put(8'h01); put(8'h80); put(8'h00); put(8'h02); put(8'h80);
    put(8'h42); put(8'h81); put(8'h82); put(8'h03); put(8'h82);
    put(8'h72); put(8'h85); put(8'h85); put(8'h05); put(8'h25);
    put(8'h46); repeat (9) put(8'h80); put(8'h80); put(8'h25);
    realign(32'hCAFE_0000);
    // R6: fifth branch byte continuing
    req = "R6";
    put(8'hFF); put(8'hFF); put(8'hFF); put(8'hFF); put(8'h8A); put(8'h80); put(8'h25);
    realign(32'h0000_1000);
    // R8: reserved header
    req = "R8";
    put(8'h02); put(8'h80); put(8'h82); put(8'h08);
    realign(32'hA5A5_5A5A);
    // R9: zero header counts toward the next alignment
    req = "R9";
    put(8'h00); zeros(3); put(8'h80); isync(32'h0BAD_F00D);
    zeros(2); put(8'h00); zeros(4); put(8'h80); isync(32'h7777_0001); put(8'h82);
    // R1: wrong byte after the pattern drops back
    req = "R1";
    put(8'h00); zeros(5); put(8'h80); put(8'h0C); put(8'h08);
    put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h05); put(8'h80);
    gap(3);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got hang exp completion");
      summary();
      $finish;
    end
  end
endmodule